// File: doc/BRIEF.md
# Dual chaotic-map keystream generator

The block runs two copies of a three-variable quadratic chaotic recurrence in signed fixed point. Both copies use the same parameter pair (a, b) and start from different seed triples. Each iteration compares the two copies variable by variable and yields three key bits. The bits are gathered into 8-bit key bytes, which leave on a valid/ready port. On the same port an XOR path combines each key byte with a caller-supplied pixel byte. The operation is its own inverse: pixels XORed on the way in are recovered by XORing them again with the same keystream.

Software or a controller writes the parameters and seeds through a small select/data write port. A one-cycle start pulse captures the written values into the working copies and clears any partly filled key byte. Identical configuration followed by start therefore always reproduces the identical byte sequence, which is how a decryptor re-derives the encryptor's key. Arithmetic is Q4.28: 4 integer bits, 28 fractional bits, 32 bits wide. Every product is floored (arithmetic shift right by 28) and truncated to 32 bits. All sums wrap in two's complement.

Top module: `chaos_keystream_gen`

## Requirements
- R1: After reset, key_valid_o stays 0 until the first start_i pulse.
- R2: Reset loads a = 1.52 and b = 0.05, and the seeds (0.3, 0.2, 0.1) for copy 0 and (0.2, 0.1, 0.2) for copy 1. Each value is rounded to Q4.28: a = 408021893, b = 13421773, 0.3 = 80530637, 0.2 = 53687091, 0.1 = 26843546.
- R3: Each iteration computes x' = 1 - a*(x*y) - x*x - y*y, y' = x and z' = y - b*z for both copies at once from their current state. Every product is (p*q) >>> 28 truncated to 32 bits, the constant 1 is 2^28, and all additions and subtractions wrap at 32 bits.
- R4: Each iteration yields three bits, in the order x, y, z. A bit is 1 when copy 0's new value is strictly greater (signed) than copy 1's new value, and 0 otherwise.
- R5: Bits fill key bytes in production order. The first bit of a byte is bit 7 and the eighth is bit 0. Bits left over from an iteration open the next byte.
- R6: While key_valid_o is 1 and key_ready_i is 0, key_o does not change and no key byte is lost. A byte is consumed only on a cycle where valid and ready are both 1.
- R7: pix_o always equals pix_i XOR key_o.
- R8: A start_i pulse copies the configured parameters and seeds into the working state and discards any buffered bits. key_valid_o is 0 in the cycle after start, and the following bytes equal the sequence from a fresh start with that configuration.
- R9: When cfg_we_i is 1, cfg_data_i is written to the register chosen by cfg_sel_i: 0 = a, 1 = b, 2..4 = copy 0 x, y, z, 5..7 = copy 1 x, y, z. Writes have no effect on the running stream until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration register select |
| cfg_data_i | input | 32 | Q4.28 value to write |
| start_i | input | 1 | Load configuration into working state and restart |
| key_ready_i | input | 1 | Consumer accepts the current key byte |
| key_valid_o | output | 1 | A key byte is available |
| key_o | output | 8 | Current key byte |
| pix_i | input | 8 | Pixel byte to combine |
| pix_o | output | 8 | Pixel byte XOR key byte |

## Verification
The assertions assume that start_i is never raised in the same cycle as a configuration write. They also assume that, whenever start_i is raised, the two seed triples differ in every variable, since equal seeds would make the comparison bits constant. The stimulus follows both rules: every write sequence completes before the next start pulse, and random seed triples are nudged by one LSB wherever a copy 1 value collides with copy 0. A directed case keeps the two copies exactly one LSB apart in each variable, which exercises the strict comparison.

// File: rtl/chaos_kg_pkg.sv
package chaos_kg_pkg;
  localparam int FX_W    = 32;
  localparam int FX_FRAC = 28;
  localparam int N_VAR   = 3;

  typedef logic signed [FX_W-1:0] fx_t;
  typedef struct packed { fx_t x; fx_t y; fx_t z; } tri_t;

  localparam fx_t FX_ONE = fx_t'(1 << FX_FRAC);
  localparam fx_t A_DEF  = 32'sd408021893;
  localparam fx_t B_DEF  = 32'sd13421773;
  localparam fx_t V_03   = 32'sd80530637;
  localparam fx_t V_02   = 32'sd53687091;
  localparam fx_t V_01   = 32'sd26843546;

  typedef enum logic [2:0] {
    SEL_A, SEL_B, SEL_X0, SEL_Y0, SEL_Z0, SEL_X1, SEL_Y1, SEL_Z1
  } cfg_sel_e;

  function automatic fx_t fx_mul(fx_t p, fx_t q);
    logic signed [2*FX_W-1:0] w;
    w = 64'(p) * 64'(q);
    return fx_t'(w >>> FX_FRAC);
  endfunction
endpackage

// File: rtl/chaos_map.sv
module chaos_map
  import chaos_kg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  input  tri_t seed_i,
  input  fx_t  a_i,
  input  fx_t  b_i,
  output tri_t nxt_o
);
  tri_t cur_q;

  always_comb begin
    nxt_o.x = FX_ONE - fx_mul(a_i, fx_mul(cur_q.x, cur_q.y))
                     - fx_mul(cur_q.x, cur_q.x) - fx_mul(cur_q.y, cur_q.y);
    nxt_o.y = cur_q.x;
    nxt_o.z = cur_q.y - fx_mul(b_i, cur_q.z);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= '0;
    else if (load_i) cur_q <= seed_i;
    else if (step_i) cur_q <= nxt_o;
  end

  // R3
  y_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> cur_q.y == $past(cur_q.x));

  // R8
  seed_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cur_q == $past(seed_i));
endmodule

// File: rtl/chaos_bit_packer.sv
module chaos_bit_packer #(
  parameter int BYTE_W = 8,
  parameter int IN_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              push_i,
  input  logic [IN_W-1:0]   bits_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int ACC_W = BYTE_W + IN_W - 1;
  localparam int CNT_W = $clog2(ACC_W + 1);

  logic [ACC_W-1:0] acc_q, shifted;
  logic [CNT_W-1:0] cnt_q;

  assign valid_o = cnt_q >= CNT_W'(BYTE_W);
  // oldest bit of the pending byte sits highest
  assign shifted = acc_q >> (cnt_q - CNT_W'(BYTE_W));
  assign byte_o  = shifted[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      acc_q <= {acc_q[ACC_W-IN_W-1:0], bits_i};
      cnt_q <= cnt_q + CNT_W'(IN_W);
    end else if (valid_o && ready_i) begin
      cnt_q <= cnt_q - CNT_W'(BYTE_W);
    end
  end

  // R6
  key_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && !clear_i |=> valid_o && $stable(byte_o));

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(ACC_W));

  // R8
  clear_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !valid_o);
endmodule

// File: rtl/chaos_keystream_gen.sv
module chaos_keystream_gen
  import chaos_kg_pkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_sel_i,
  input  logic [FX_W-1:0]  cfg_data_i,
  input  logic             start_i,
  input  logic             key_ready_i,
  output logic             key_valid_o,
  output logic [KEY_W-1:0] key_o,
  input  logic [KEY_W-1:0] pix_i,
  output logic [KEY_W-1:0] pix_o
);
  localparam int N_COPY = 2;

  fx_t  a_cfg_q, b_cfg_q, a_act_q, b_act_q;
  tri_t seed_cfg_q [N_COPY];
  tri_t nxt [N_COPY];
  logic run_q, step;
  logic [N_VAR-1:0] bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_cfg_q       <= A_DEF;
      b_cfg_q       <= B_DEF;
      seed_cfg_q[0] <= '{x: V_03, y: V_02, z: V_01};
      seed_cfg_q[1] <= '{x: V_02, y: V_01, z: V_02};
    end else if (cfg_we_i) begin
      case (cfg_sel_e'(cfg_sel_i))
        SEL_A:  a_cfg_q         <= fx_t'(cfg_data_i);
        SEL_B:  b_cfg_q         <= fx_t'(cfg_data_i);
        SEL_X0: seed_cfg_q[0].x <= fx_t'(cfg_data_i);
        SEL_Y0: seed_cfg_q[0].y <= fx_t'(cfg_data_i);
        SEL_Z0: seed_cfg_q[0].z <= fx_t'(cfg_data_i);
        SEL_X1: seed_cfg_q[1].x <= fx_t'(cfg_data_i);
        SEL_Y1: seed_cfg_q[1].y <= fx_t'(cfg_data_i);
        default: seed_cfg_q[1].z <= fx_t'(cfg_data_i);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      a_act_q <= '0;
      b_act_q <= '0;
    end else if (start_i) begin
      run_q   <= 1'b1;
      a_act_q <= a_cfg_q;
      b_act_q <= b_cfg_q;
    end
  end

  assign step = run_q && !key_valid_o && !start_i;

  for (genvar g = 0; g < N_COPY; g++) begin : g_copy
    chaos_map u_map (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (start_i),
      .step_i (step),
      .seed_i (seed_cfg_q[g]),
      .a_i    (a_act_q),
      .b_i    (b_act_q),
      .nxt_o  (nxt[g])
    );
  end

  // x is the oldest bit of each triple
  assign bits = {$signed(nxt[0].x) > $signed(nxt[1].x),
                 $signed(nxt[0].y) > $signed(nxt[1].y),
                 $signed(nxt[0].z) > $signed(nxt[1].z)};

  chaos_bit_packer #(.BYTE_W(KEY_W), .IN_W(N_VAR)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i),
    .push_i  (step),
    .bits_i  (bits),
    .ready_i (key_ready_i),
    .valid_o (key_valid_o),
    .byte_o  (key_o)
  );

  assign pix_o = pix_i ^ key_o;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !key_valid_o);

  // R8
  seed_diff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> seed_cfg_q[0].x != seed_cfg_q[1].x &&
                seed_cfg_q[0].y != seed_cfg_q[1].y &&
                seed_cfg_q[0].z != seed_cfg_q[1].z);

  // R9
  no_cfg_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && cfg_we_i));
endmodule

// File: tb/test_chaos_keystream_gen.sv
module test_chaos_keystream_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [31:0] cfg_data_i = '0;
  logic        start_i = 1'b0;
  logic        key_ready_i = 1'b0;
  logic        key_valid_o;
  logic [7:0]  key_o, pix_i = '0, pix_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  int   ma, mb;
  int   ms [2][3];
  int   cfg [8];
  bit   bq [$];
  bit   hold_pend = 0;
  logic [7:0] held;

  always #4 clk_i = ~clk_i;

  chaos_keystream_gen i_chaos_keystream_gen (.*);

  function automatic int fmul(int p, int q);
    longint w;
    w = longint'(p) * longint'(q);
    return int'(w >>> 28);
  endfunction

  function automatic void model_start();
    ma = cfg[0]; mb = cfg[1];
    for (int c = 0; c < 2; c++)
      for (int v = 0; v < 3; v++) ms[c][v] = cfg[2 + 3*c + v];
    bq.delete();
  endfunction

  function automatic void model_step();
    int n [2][3];
    for (int c = 0; c < 2; c++) begin
      n[c][0] = (1 << 28) - fmul(ma, fmul(ms[c][0], ms[c][1]))
                - fmul(ms[c][0], ms[c][0]) - fmul(ms[c][1], ms[c][1]);
      n[c][1] = ms[c][0];
      n[c][2] = ms[c][1] - fmul(mb, ms[c][2]);
    end
    for (int v = 0; v < 3; v++) bq.push_back(n[0][v] > n[1][v]);
    ms = n;
  endfunction

  function automatic logic [7:0] exp_byte();
    logic [7:0] b = '0;
    while (bq.size() < 8) model_step();
    for (int i = 0; i < 8; i++) b = {b[6:0], bq.pop_front()};
    return b;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(int sel, int val);
    @(negedge clk_i);
    key_ready_i = 0;
    cfg_we_i = 1; cfg_sel_i = 3'(sel); cfg_data_i = val;
    @(negedge clk_i);
    cfg_we_i = 0;
    cfg[sel] = val;
  endtask

  task automatic pulse_start();
    @(negedge clk_i);
    key_ready_i = 0; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    #1;
    check(key_valid_o == 0, "R8 valid after start", key_valid_o, 0);
    model_start();
    hold_pend = 0;
  endtask

  task automatic run_stream(int nbytes, int rdy_pct);
    int got = 0;
    while (got < nbytes) begin
      @(negedge clk_i);
      key_ready_i = ($urandom_range(0, 99) < rdy_pct);
      pix_i = 8'($urandom);
      #1;
      if (key_valid_o) begin
        if (hold_pend) check(key_o == held, "R6 hold", key_o, held);
        if (key_ready_i) begin
          logic [7:0] e;
          e = exp_byte();
          check(key_o == e, "R3 R4 R5 key byte", key_o, e);
          check(pix_o == (pix_i ^ e), "R7 xor", pix_o, pix_i ^ e);
          hold_pend = 0;
          got++;
        end else begin
          hold_pend = 1; held = key_o;
        end
      end
    end
    @(negedge clk_i);
    key_ready_i = 0;
  endtask

  task automatic rand_cfg(bit lsb_apart);
    int v [8];
    v[0] = 32'sd408021893 + int'($urandom_range(0, 1 << 24)) - (1 << 23);
    v[1] = int'($urandom_range(0, 1 << 25));
    for (int k = 2; k < 5; k++) begin
      v[k] = int'($urandom_range(0, 1 << 28)) - (1 << 27);
      v[k+3] = lsb_apart ? v[k] + 1 : int'($urandom_range(0, 1 << 28)) - (1 << 27);
      if (v[k+3] == v[k]) v[k+3] = v[k] - 1;
    end
    for (int k = 0; k < 8; k++) cfg_write(k, v[k]);
  endtask

  initial begin
    int s;
    s = $urandom(32'd2024);
    cfg = '{408021893, 13421773, 80530637, 53687091, 26843546,
            53687091, 26843546, 53687091};
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    begin
      int seen = 0;
      repeat (20) begin
        @(negedge clk_i);
        key_ready_i = 1;
        if (key_valid_o) seen++;
      end
      check(seen == 0, "R1 idle after reset", seen, 0);
      key_ready_i = 0;
    end

    // R2 reset defaults
    pulse_start();
    run_stream(40, 70);

    // R9 writes ignored until next start
    rand_cfg(0);
    begin
      int keep [8];
      keep = cfg;
      cfg = '{408021893, 13421773, 80530637, 53687091, 26843546,
              53687091, 26843546, 53687091};
      run_stream(12, 80);
      cfg = keep;
    end
    pulse_start();
    run_stream(40, 60);

    // R8 restart mid-stream reproduces, with leftover bits discarded
    for (int it = 0; it < 6; it++) begin
      if (it % 2 == 1) rand_cfg(0);
      pulse_start();
      run_stream(int'($urandom_range(1, 9)), 90);
      repeat (int'($urandom_range(0, 3))) @(negedge clk_i);
      pulse_start();
      run_stream(20, 50);
    end

    // R4 strict compare with copies one LSB apart
    rand_cfg(1);
    pulse_start();
    run_stream(30, 100);

    // R6 long stalls
    pulse_start();
    run_stream(20, 10);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule